// File: doc/BRIEF.md
# Byte-Paired 16-Bit Parallel Port

This block joins two byte-wide ports into one 16-bit parallel data path that a bus master reaches through byte-wide registers. A word is moved as two byte accesses. The high byte (port A) is always accessed first and the low byte (port B) second. Each of the 16 external pins has a direction bit, and that bit only switches the output driver. A control register selects one of two submodes:
- **Submode X0** gives double-buffered input and single-buffered output.
- **Submode X1** gives double-buffered output and non-latched input.

One handshake input (H3) and one handshake output (H4) pace the 16-bit transfers. A DMA request output follows the H3 transfer path. All handshake, status and DMA activity is keyed to the port B access, never to the port A access. In submode X1 a port A write is parked in a holding byte until the port B write commits the whole word.

The handshake is run by a three-state machine:
- **HS_IDLE**: H4 is low.
- **HS_HOLD**: H4 is held high until the next valid H3 edge.
- **HS_PULSE**: H4 is high for a fixed count of clocks.

Transitions:
- **load**: HS_IDLE to HS_HOLD or HS_PULSE in X1, when an output word is waiting. The word moves to the final output latch on this transition.
- **ready**: HS_IDLE to HS_HOLD in X0 interlocked, when the input staging latch is empty.
- **capture**: HS_IDLE to HS_PULSE in X0 pulsed, on an H3 capture.
- **ack**: HS_HOLD to HS_IDLE on an H3 edge.
- **expire**: HS_PULSE to HS_IDLE after the count.
- **abort**: any state to HS_IDLE when the handshake is disabled or the control register is written.

Top module: `pp16_port`

Register map (3-bit address):

| Address | Register |
|---|---|
| 0 | control |
| 1 | direction of pins 15:8 |
| 2 | direction of pins 7:0 |
| 3 | port A data |
| 4 | port B data |
| 5 | status |

Control register bits:

| Bit | Meaning |
|---|---|
| 0 | 1 selects submode X1 |
| 1 | handshake enable |
| 2 | pulsed handshake (0 is interlocked) |
| 3 | 1 means H3 falling edge is valid, 0 means rising |
| 4 | DMA request enable |

Status register bits:

| Bit | Meaning |
|---|---|
| 0 | H3 edge flag |
| 1 | final input latch full |
| 2 | output staging latch full |

## Requirements
- R1: After reset every register reads 0, pin_oe is 0, hs_out is 0 and dma_req is 0.
- R2: pin_oe[15:8] equals the port A direction register and pin_oe[7:0] equals the port B direction register.
- R3: The output latch accepts writes whatever the direction bits, and pin_out always shows it. On a data register read, a bit with direction 1 returns the output latch bit.
- R4: In X0 a port A write sets pin_out[15:8] and a port B write sets pin_out[7:0], one clock after the write.
- R5: In X1 a port A write leaves pin_out unchanged. A following port B write places {held A byte, B byte} on pin_out. With the handshake off this happens one clock after the write.
- R6: In X1 a direction-0 bit reads the live pin_in value in the same cycle.
- R7: A valid H3 edge (polarity from control bit 3) sets status bit 0. Writing 1 to status bit 0 clears it, except that an edge in the same cycle wins.
- R8: In X1 interlocked, a port B write puts the word on pin_out and raises hs_out. hs_out stays high until the next valid H3 edge, then falls.
- R9: In X1 pulsed, hs_out is high for exactly 4 clocks per committed word.
- R10: In X0 with the handshake on:
  - an H3 edge captures pin_in into a staging latch;
  - the staging latch moves to the final latch when the final latch is empty, and status bit 1 then shows the final latch full;
  - a port B read frees the final latch, and a port A read does not.
- R11: With the handshake disabled, hs_out stays 0. In X0, direction-0 bits then read pin_in as sampled one clock earlier.
- R12: With control bits 1 and 4 set, dma_req is 1 when the X1 staging latch is empty, or in X0 when the final input latch is full; otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| pin_in | input | 16 | External pin input values |
| pin_out | output | 16 | Final output latch to the pins |
| pin_oe | output | 16 | Output driver enables |
| hs_in | input | 1 | Handshake/status input H3 |
| hs_out | output | 1 | Handshake output H4 |
| dma_req | output | 1 | DMA request tied to the H3 transfer path |

## Verification
Two pairs of events can land on the same clock edge.

The first pair is a software clear of the H3 flag and a new H3 edge. The bench raises hs_in so that the synchronised edge lands on the same edge as a status write of 1. It then expects the flag to stay set, and it expects a clear on its own to drop the flag.

The second pair is a port B read freeing the final input latch while a second captured word waits in staging. The bench stacks two captures, then reads port A and checks that the full bit holds. It then reads port B and checks that the staged word moves in on the next clock.

// File: rtl/pp16_pkg.sv
package pp16_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL   = 3'd0,
        RA_DIR_HI = 3'd1,
        RA_DIR_LO = 3'd2,
        RA_DATA_A = 3'd3,
        RA_DATA_B = 3'd4,
        RA_STATUS = 3'd5
    } reg_addr_e;

    localparam int CB_X1     = 0;
    localparam int CB_HS_EN  = 1;
    localparam int CB_PULSED = 2;
    localparam int CB_FALL   = 3;
    localparam int CB_DMA_EN = 4;

    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_HOLD  = 2'd1,
        HS_PULSE = 2'd2
    } hs_state_e;
endpackage

// File: rtl/pp16_edge.sv
module pp16_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    input  logic falling,
    output logic pulse
);
    logic s1_q, s2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else begin
            s1_q <= async_in;
            s2_q <= s1_q;
        end
    end

    assign pulse = falling ? (~s1_q & s2_q) : (s1_q & ~s2_q);

    // R7: one input transition yields a single-cycle edge
    p_edge_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> (!pulse || !$stable(falling)));
endmodule

// File: rtl/pp16_hs_fsm.sv
module pp16_hs_fsm
    import pp16_pkg::*;
#(
    parameter int PULSE_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic out_mode,
    input  logic pulsed,
    input  logic edge_det,
    input  logic word_ready,
    input  logic stage_full,
    input  logic cap,
    output logic h4,
    output logic load_out
);
    localparam int CW = $clog2(PULSE_LEN + 1);

    hs_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_q == HS_PULSE && state_d == HS_PULSE) ? cnt_q + 1'b1 : '0;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = HS_IDLE;
        end else begin
            unique case (state_q)
                HS_IDLE: begin
                    if (out_mode) begin
                        if (word_ready) state_d = pulsed ? HS_PULSE : HS_HOLD;
                    end else if (pulsed) begin
                        if (cap) state_d = HS_PULSE;
                    end else if (!stage_full) begin
                        state_d = HS_HOLD;
                    end
                end
                HS_HOLD:  if (edge_det) state_d = HS_IDLE;
                HS_PULSE: if (cnt_q == CW'(PULSE_LEN - 1)) state_d = HS_IDLE;
                default:  state_d = HS_IDLE;
            endcase
        end
    end

    always_comb begin
        h4       = (state_q == HS_HOLD) || (state_q == HS_PULSE);
        load_out = en && out_mode && (state_q == HS_IDLE) && word_ready;
    end

    // R8: an interlocked hold ends only on an H3 edge
    p_hold_until_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HS_HOLD && en && !edge_det) |=> state_q == HS_HOLD);
    // R9: the pulse counter never passes its length
    p_pulse_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HS_PULSE) |-> (cnt_q < CW'(PULSE_LEN)));
    // R11: a disabled handshake leaves H4 low on the next cycle
    p_h4_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !h4);
endmodule

// File: rtl/pp16_port.sv
module pp16_port
    import pp16_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int PULSE_LEN = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BYTE_W-1:0]   bus_wdata,
    output logic [BYTE_W-1:0]   bus_rdata,
    input  logic [2*BYTE_W-1:0] pin_in,
    output logic [2*BYTE_W-1:0] pin_out,
    output logic [2*BYTE_W-1:0] pin_oe,
    input  logic                hs_in,
    output logic                hs_out,
    output logic                dma_req
);
    localparam int WORD_W = 2 * BYTE_W;

    logic [BYTE_W-1:0] ctrl_q, dir_hi_q, dir_lo_q, hold_a_q;
    logic [WORD_W-1:0] fol_q, iol_q, stage_q, fil_q;
    logic iol_full_q, stage_full_q, fil_full_q, h3s_q;

    logic out_mode, hs_en, pulsed, falling, dma_en;
    logic wr_ctrl, wr_dhi, wr_dlo, wr_a, wr_b, wr_stat, rd_b;
    logic edge_det, cap, mv, rd_b_free, load_out, fsm_en;
    logic [WORD_W-1:0] dir_w, in_word, view_w;

    assign out_mode = ctrl_q[CB_X1];
    assign hs_en    = ctrl_q[CB_HS_EN];
    assign pulsed   = ctrl_q[CB_PULSED];
    assign falling  = ctrl_q[CB_FALL];
    assign dma_en   = ctrl_q[CB_DMA_EN];

    assign wr_ctrl = bus_wr && (bus_addr == RA_CTRL);
    assign wr_dhi  = bus_wr && (bus_addr == RA_DIR_HI);
    assign wr_dlo  = bus_wr && (bus_addr == RA_DIR_LO);
    assign wr_a    = bus_wr && (bus_addr == RA_DATA_A);
    assign wr_b    = bus_wr && (bus_addr == RA_DATA_B);
    assign wr_stat = bus_wr && (bus_addr == RA_STATUS);
    assign rd_b    = bus_rd && (bus_addr == RA_DATA_B);

    pp16_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (hs_in),
        .falling  (falling),
        .pulse    (edge_det)
    );

    assign cap       = edge_det && hs_en && !out_mode && !stage_full_q;
    assign rd_b_free = rd_b && hs_en && !out_mode;
    assign mv        = stage_full_q && (!fil_full_q || rd_b_free);
    assign fsm_en    = hs_en && !wr_ctrl;

    pp16_hs_fsm #(.PULSE_LEN(PULSE_LEN)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (fsm_en),
        .out_mode   (out_mode),
        .pulsed     (pulsed),
        .edge_det   (edge_det),
        .word_ready (iol_full_q),
        .stage_full (stage_full_q),
        .cap        (cap),
        .h4         (hs_out),
        .load_out   (load_out)
    );

    // configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            dir_hi_q <= '0;
            dir_lo_q <= '0;
            hold_a_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q   <= bus_wdata;
            if (wr_dhi)  dir_hi_q <= bus_wdata;
            if (wr_dlo)  dir_lo_q <= bus_wdata;
            if (wr_a)    hold_a_q <= bus_wdata;
        end
    end

    // output path: single buffered (X0) or held-A double buffered (X1)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fol_q      <= '0;
            iol_q      <= '0;
            iol_full_q <= 1'b0;
        end else begin
            if (!out_mode) begin
                if (wr_a) fol_q[WORD_W-1:BYTE_W] <= bus_wdata;
                if (wr_b) fol_q[BYTE_W-1:0]      <= bus_wdata;
            end else if (!hs_en) begin
                if (wr_b) fol_q <= {hold_a_q, bus_wdata};
            end else if (load_out) begin
                fol_q <= iol_q;
            end

            if (out_mode && hs_en) begin
                if (wr_b) begin
                    iol_q      <= {hold_a_q, bus_wdata};
                    iol_full_q <= 1'b1;
                end else if (load_out) begin
                    iol_full_q <= 1'b0;
                end
            end else begin
                iol_full_q <= 1'b0;
            end
        end
    end

    // input path: staging latch then final input latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q      <= '0;
            fil_q        <= '0;
            stage_full_q <= 1'b0;
            fil_full_q   <= 1'b0;
        end else if (out_mode) begin
            stage_full_q <= 1'b0;
            fil_full_q   <= 1'b0;
        end else if (!hs_en) begin
            fil_q        <= pin_in;
            stage_full_q <= 1'b0;
            fil_full_q   <= 1'b0;
        end else begin
            if (cap) stage_q <= pin_in;
            if (mv)  fil_q   <= stage_q;
            stage_full_q <= cap ? 1'b1 : (mv ? 1'b0 : stage_full_q);
            fil_full_q   <= mv  ? 1'b1 : (rd_b_free ? 1'b0 : fil_full_q);
        end
    end

    // edge status flag: edge beats software clear
    always_ff @(posedge clk) begin
        if (!rst_n)                     h3s_q <= 1'b0;
        else if (edge_det)              h3s_q <= 1'b1;
        else if (wr_stat && bus_wdata[0]) h3s_q <= 1'b0;
    end

    assign dir_w   = {dir_hi_q, dir_lo_q};
    assign in_word = out_mode ? pin_in : fil_q;
    assign view_w  = (dir_w & fol_q) | (~dir_w & in_word);

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            RA_CTRL:   bus_rdata = ctrl_q;
            RA_DIR_HI: bus_rdata = dir_hi_q;
            RA_DIR_LO: bus_rdata = dir_lo_q;
            RA_DATA_A: bus_rdata = view_w[WORD_W-1:BYTE_W];
            RA_DATA_B: bus_rdata = view_w[BYTE_W-1:0];
            RA_STATUS: bus_rdata = BYTE_W'({iol_full_q, fil_full_q, h3s_q});
            default:   bus_rdata = '0;
        endcase
    end

    assign pin_out = fol_q;
    assign pin_oe  = dir_w;
    assign dma_req = dma_en && hs_en && (out_mode ? !iol_full_q : fil_full_q);

    // R7: a valid edge always leaves the flag set
    p_h3s_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        edge_det |=> h3s_q);
    // R5: a lone port A write in X1 does not disturb the pins
    p_hold_no_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_a && out_mode && !hs_en && !wr_ctrl) |=> $stable(pin_out));
    // R10: the final input latch stays full until a port B read
    p_fil_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_en && !out_mode && fil_full_q && !rd_b && !wr_ctrl) |=> fil_full_q);
    // R10: a capture only happens into an empty staging latch
    p_cap_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> stage_full_q);
endmodule

// File: tb/tb_pp16_port.sv
`timescale 1ns/1ps
module tb_pp16_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out, pin_oe;
    logic        hs_in = 1'b0;
    logic        hs_out, dma_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pp16_port dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .hs_in(hs_in), .hs_out(hs_out), .dma_req(dma_req)
    );

    localparam logic [2:0] A_CTRL = 3'd0, A_DHI = 3'd1, A_DLO = 3'd2,
                           A_PA = 3'd3, A_PB = 3'd4, A_ST = 3'd5;

    function automatic logic [15:0] merge(input logic [15:0] dir, input logic [15:0] lat,
                                          input logic [15:0] inp);
        return (dir & lat) | (~dir & inp);
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic h3_pulse();
        hs_in = 1'b1; idle(3);
        hs_in = 1'b0; idle(3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [15:0] prev, dir;
        logic [7:0] a, b;
        int cnt;
        void'($urandom(32'd1234));
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        chk("R1 oe", pin_oe, 16'h0);
        chk("R1 h4", {15'b0, hs_out}, 16'h0);
        chk("R1 dma", {15'b0, dma_req}, 16'h0);
        rd(A_CTRL, d); chk("R1 ctrl", {8'h0, d}, 16'h0);
        rd(A_ST, d);   chk("R1 status", {8'h0, d}, 16'h0);
        chk("R1 pins", pin_out, 16'h0);

        // R2 R3 R4 R11: X0, handshake off, random directions and data
        wr(A_CTRL, 8'h00);
        for (int i = 0; i < 30; i++) begin
            dir = 16'($urandom);
            a = 8'($urandom); b = 8'($urandom);
            wr(A_DHI, dir[15:8]); wr(A_DLO, dir[7:0]);
            wr(A_PA, a); wr(A_PB, b);
            pin_in = 16'($urandom);
            idle(2);
            chk("R2 oe", pin_oe, dir);
            chk("R4 pins", pin_out, {a, b});
            rd(A_PA, d); chk("R3 readA", {8'h0, d}, {8'h0, merge(dir, {a, b}, pin_in)} >> 8);
            rd(A_PB, d); chk("R11 readB", {8'h0, d}, {8'h0, merge(dir, {a, b}, pin_in) & 16'h00FF});
            chk("R11 h4", {15'b0, hs_out}, 16'h0);
        end
        // R3: direction 0 still latches writes
        wr(A_DHI, 8'h00); wr(A_DLO, 8'h00);
        wr(A_PA, 8'h5A); wr(A_PB, 8'hC3); idle(1);
        chk("R3 oe off", pin_oe, 16'h0);
        chk("R3 latch", pin_out, 16'h5AC3);

        // R5 R6: X1 without handshake
        wr(A_CTRL, 8'h01);
        for (int i = 0; i < 30; i++) begin
            a = 8'($urandom); b = 8'($urandom);
            prev = pin_out;
            wr(A_PA, a); idle(1);
            chk("R5 held", pin_out, prev);
            wr(A_PB, b);
            chk("R5 commit", pin_out, {a, b});
            dir = 16'($urandom);
            wr(A_DHI, dir[15:8]); wr(A_DLO, dir[7:0]);
            pin_in = 16'($urandom);
            rd(A_PA, d); chk("R6 live", {8'h0, d}, {8'h0, merge(dir, {a, b}, pin_in)} >> 8);
            chk("R11 h4 x1", {15'b0, hs_out}, 16'h0);
        end

        // R7: edge flag, clear, collision, polarity
        wr(A_CTRL, 8'h00);
        h3_pulse();
        rd(A_ST, d); chk("R7 set", {15'b0, d[0]}, 16'h1);
        wr(A_ST, 8'h01);
        rd(A_ST, d); chk("R7 clear", {15'b0, d[0]}, 16'h0);
        hs_in = 1'b1; idle(1);
        wr(A_ST, 8'h01);
        rd(A_ST, d); chk("R7 edge wins", {15'b0, d[0]}, 16'h1);
        idle(2); hs_in = 1'b0; idle(3);
        wr(A_ST, 8'h01);
        wr(A_CTRL, 8'h08);
        hs_in = 1'b1; idle(3);
        rd(A_ST, d); chk("R7 rise ignored", {15'b0, d[0]}, 16'h0);
        hs_in = 1'b0; idle(3);
        rd(A_ST, d); chk("R7 fall sets", {15'b0, d[0]}, 16'h1);

        // R8 R12: X1 interlocked with DMA
        wr(A_DHI, 8'hFF); wr(A_DLO, 8'hFF);
        wr(A_CTRL, 8'h13);
        chk("R12 dma empty", {15'b0, dma_req}, 16'h1);
        wr(A_PA, 8'hAB);
        chk("R8 no h4 on A", {15'b0, hs_out}, 16'h0);
        wr(A_PB, 8'hCD);
        chk("R12 dma full", {15'b0, dma_req}, 16'h0);
        idle(2);
        chk("R8 h4 up", {15'b0, hs_out}, 16'h1);
        chk("R8 word", pin_out, 16'hABCD);
        chk("R12 dma again", {15'b0, dma_req}, 16'h1);
        idle(3);
        chk("R8 h4 held", {15'b0, hs_out}, 16'h1);
        h3_pulse();
        chk("R8 h4 down", {15'b0, hs_out}, 16'h0);

        // R9: pulsed width
        wr(A_CTRL, 8'h07);
        wr(A_PA, 8'h12); wr(A_PB, 8'h34);
        cnt = 0;
        for (int i = 0; i < 12; i++) begin
            if (hs_out) cnt++;
            idle(1);
        end
        chk("R9 width", 16'(cnt), 16'd4);
        chk("R9 word", pin_out, 16'h1234);

        // R10 R12: X0 interlocked input double buffering
        wr(A_DHI, 8'h00); wr(A_DLO, 8'h00);
        wr(A_CTRL, 8'h12);
        idle(1);
        chk("R10 ready", {15'b0, hs_out}, 16'h1);
        pin_in = 16'h1234; h3_pulse(); idle(1);
        chk("R12 dma in", {15'b0, dma_req}, 16'h1);
        pin_in = 16'h5678; h3_pulse(); idle(1);
        pin_in = 16'h0000;
        rd(A_ST, d); chk("R10 full", {15'b0, d[1]}, 16'h1);
        rd(A_PA, d); chk("R10 A1", {8'h0, d}, 16'h0012);
        rd(A_ST, d); chk("R10 A no free", {15'b0, d[1]}, 16'h1);
        rd(A_PB, d); chk("R10 B1", {8'h0, d}, 16'h0034);
        idle(1);
        rd(A_PA, d); chk("R10 A2", {8'h0, d}, 16'h0056);
        rd(A_PB, d); chk("R10 B2", {8'h0, d}, 16'h0078);
        idle(1);
        rd(A_ST, d); chk("R10 empty", {15'b0, d[1]}, 16'h0);
        chk("R12 dma idle", {15'b0, dma_req}, 16'h0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule